// File: doc/BRIEF.md
# Root-Port Interrupt Status Aggregator

This block gathers thirty-two interrupt sources belonging to one root port into a single interrupt line. The four lowest sources are legacy level-sensitive lines. Their status bits follow the live input level. Every other source is a rising-edge event. An edge event is held in a status bit until software writes a one to that bit. Each source also has a mask bit. Software can write the whole mask at once, or it can change single bits atomically through a set port and a clear port. Those two ports spare software a read-modify-write sequence.

Software reaches the block through a simple register port. A write strobe comes with an address and data, and read data is returned combinationally for the current address. The combined interrupt output is a registered OR of every status bit whose mask bit is clear. Out of reset every source is masked.

Top module: `rp_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF, every edge status bit reads 0 and `irq_o` is low.
- R2: A write to offset 0x108 sets each mask bit whose data bit is one and leaves the other mask bits unchanged.
- R3: A write to offset 0x10C clears each mask bit whose data bit is one and leaves the other mask bits unchanged.
- R4: A write to offset 0x104 loads the whole mask from the write data.
- R5: Status bits 0 to 3 read the live level of sources 0 to 3, and writing ones to them at offset 0x100 has no effect.
- R6: A rising edge on any source 4 to 31 sets its status bit on the next clock, and the bit stays set after the source falls.
- R7: Writing a one to an edge status bit at offset 0x100 clears it, and zero data bits leave status unchanged.
- R8: If a rising edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` equals, one clock later, the OR over all bits of status AND NOT mask.
- R10: Reads at offsets 0x108 and 0x10C return the current mask, and reads at any unmapped offset return 0.
- R11: Writing all ones to 0x108 and then all ones to 0x100 leaves every source masked, every edge bit cleared and `irq_o` low.
- R12: An edge source held high after its bit is cleared does not set the bit again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs; bits 0-3 level, others edge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the offset on `reg_addr_i` |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
Five properties are checked on every cycle. Set and clear writes must leave exactly the addressed mask bits in the new state. A rising edge must always land in status, even when a clearing write hits the same bit, and edge bits never drop unless a status write occurs. The output must track the masked status with a one-cycle lag. Other behaviours can only be shown by the bench's scenarios: that level bits ignore acknowledges, that every offset reads back correctly, that a held source does not latch again, and the reset values.

// File: rtl/rp_irq_pkg.sv
// Package: shared widths, register offsets and decode type for the
// root-port interrupt aggregator.
// Assumes byte offsets within a 4 KiB register window.
package rp_irq_pkg;

    localparam int unsigned IRQ_NUM_SRC   = 32;
    localparam int unsigned IRQ_NUM_LEVEL = 4;
    localparam int unsigned IRQ_ADDR_W    = 12;

    localparam logic [IRQ_ADDR_W-1:0] OFS_STATUS = 12'h100;
    localparam logic [IRQ_ADDR_W-1:0] OFS_MASK   = 12'h104;
    localparam logic [IRQ_ADDR_W-1:0] OFS_MSET   = 12'h108;
    localparam logic [IRQ_ADDR_W-1:0] OFS_MCLR   = 12'h10C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;

    // Map a byte offset to the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [IRQ_ADDR_W-1:0] a);
        case (a)
            OFS_STATUS: decode_ofs = SEL_STATUS;
            OFS_MASK:   decode_ofs = SEL_MASK;
            OFS_MSET:   decode_ofs = SEL_MSET;
            OFS_MCLR:   decode_ofs = SEL_MCLR;
            default:    decode_ofs = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rp_irq_mask.sv
// Module: rp_irq_mask
// Holds the per-source mask. Supports a full load, an atomic set and an
// atomic clear. At most one strobe is active per cycle (the decoder
// guarantees this). Resets to all ones so every source starts masked.
module rp_irq_mask #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               set_i,
    input  logic               clr_i,
    input  logic [NUM_SRC-1:0] data_i,
    output logic [NUM_SRC-1:0] mask_o
);

    logic [NUM_SRC-1:0] mask_q;

    // Update the mask from whichever write strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (load_i) begin
            mask_q <= data_i;
        end else if (set_i) begin
            mask_q <= mask_q | data_i;
        end else if (clr_i) begin
            mask_q <= mask_q & ~data_i;
        end
    end

    assign mask_o = mask_q;

    // R2: set write turns on exactly the requested bits
    a_r2_set_bits_on: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && set_i) |=> ((mask_o & $past(data_i)) == $past(data_i)));

    // R3: clear write turns off exactly the requested bits
    a_r3_clr_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_i) |=> ((mask_o & $past(data_i)) == '0));

endmodule

// File: rtl/rp_irq_status.sv
// Module: rp_irq_status
// Builds the status vector. The lowest NUM_LEVEL bits mirror the live
// source levels. Every higher bit latches a rising edge until a
// write-one-to-clear. A new edge beats a clear in the same cycle.
// Assumes src_i is already synchronous to clk.
module rp_irq_status #(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_LEVEL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               ack_i,
    input  logic [NUM_SRC-1:0] ack_data_i,
    output logic [NUM_SRC-1:0] status_o
);

    localparam logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'((64'd1 << NUM_LEVEL) - 64'd1);
    localparam logic [NUM_SRC-1:0] EDGE_MASK  = ~LEVEL_MASK;

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] wipe;

    // Remember last cycle's source levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    assign rise = src_i & ~src_q & EDGE_MASK;
    assign wipe = ack_i ? ack_data_i : '0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (i < NUM_LEVEL) begin : g_level
            // Level source: status follows the input directly.
            assign status_o[i] = src_i[i];
        end else begin : g_edge
            logic hit_q;
            // Edge source: latch on rise, clear on acknowledge, rise wins.
            always_ff @(posedge clk) begin
                if (!rst_n)       hit_q <= 1'b0;
                else if (rise[i]) hit_q <= 1'b1;
                else if (wipe[i]) hit_q <= 1'b0;
            end
            assign status_o[i] = hit_q;
        end
    end

    // R6 / R8: every detected rise is visible in status next cycle
    a_r8_rise_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (rise != '0)) |=> ((status_o & $past(rise)) == $past(rise)));

    // R6: without an acknowledge no edge bit ever drops
    a_r6_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ack_i) |=> (($past(status_o) & ~status_o & EDGE_MASK) == '0));

endmodule

// File: rtl/rp_irq_combine.sv
// Module: rp_irq_combine
// Reduces unmasked status to one registered interrupt line.
module rp_irq_combine #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_o
);

    logic irq_q;

    // Register the OR of all pending, unmasked sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_i & ~mask_i);
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/rp_irq_ctrl.sv
// Module: rp_irq_ctrl (top)
// Per-port interrupt aggregator: decodes register writes, holds the mask
// and status, returns read data and drives the combined interrupt.
// Assumes one register access per cycle and reads that are combinational.
module rp_irq_ctrl
    import rp_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC   = IRQ_NUM_SRC,
    parameter int unsigned NUM_LEVEL = IRQ_NUM_LEVEL,
    parameter int unsigned ADDR_W    = IRQ_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               irq_o
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] status_w;

    assign sel = decode_ofs(reg_addr_i);

    rp_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (reg_wr_i && (sel == SEL_MASK)),
        .set_i  (reg_wr_i && (sel == SEL_MSET)),
        .clr_i  (reg_wr_i && (sel == SEL_MCLR)),
        .data_i (reg_wdata_i),
        .mask_o (mask_w)
    );

    rp_irq_status #(.NUM_SRC(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .ack_i      (reg_wr_i && (sel == SEL_STATUS)),
        .ack_data_i (reg_wdata_i),
        .status_o   (status_w)
    );

    rp_irq_combine #(.NUM_SRC(NUM_SRC)) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_w),
        .mask_i   (mask_w),
        .irq_o    (irq_o)
    );

    // Select read data for the addressed register.
    always_comb begin
        case (sel)
            SEL_STATUS:                  reg_rdata_o = status_w;
            SEL_MASK, SEL_MSET, SEL_MCLR: reg_rdata_o = mask_w;
            default:                     reg_rdata_o = '0;
        endcase
    end

    // R9: output reflects previous cycle's unmasked status
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == $past(|(status_w & ~mask_w))));

endmodule

// File: tb/tb_rp_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rp_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rp_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // kind: 0 drive sources, 1 register write, 2 read check, 3 irq check
    localparam int NV = 25;
    localparam logic [81:0] VEC [0:NV-1] = '{
        {2'd2, 12'h104, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 mask reset
        {2'd2, 12'h100, 32'h0,        32'h00000000, 4'd1},  // R1 status reset
        {2'd0, 12'h000, 32'h00001000, 32'h0,        4'd6},  // R6 bit 12 rises
        {2'd2, 12'h100, 32'h0,        32'h00001000, 4'd6},  // R6 latched
        {2'd3, 12'h000, 32'h0,        32'h0,        4'd9},  // R9 masked -> low
        {2'd1, 12'h10C, 32'h00001000, 32'h0,        4'd3},  // R3 unmask bit 12
        {2'd2, 12'h10C, 32'h0,        32'hFFFFEFFF, 4'd3},  // R3 / R10
        {2'd3, 12'h000, 32'h0,        32'h1,        4'd9},  // R9 high
        {2'd0, 12'h000, 32'h00000000, 32'h0,        4'd6},  // R6 source falls
        {2'd2, 12'h100, 32'h0,        32'h00001000, 4'd6},  // R6 still held
        {2'd1, 12'h100, 32'h00001000, 32'h0,        4'd7},  // R7 clear
        {2'd2, 12'h100, 32'h0,        32'h00000000, 4'd7},  // R7 cleared
        {2'd3, 12'h000, 32'h0,        32'h0,        4'd9},  // R9 low again
        {2'd0, 12'h000, 32'h00000005, 32'h0,        4'd5},  // R5 level lines
        {2'd2, 12'h100, 32'h0,        32'h00000005, 4'd5},  // R5 live level
        {2'd1, 12'h100, 32'h0000000F, 32'h0,        4'd5},  // R5 ack ignored
        {2'd2, 12'h100, 32'h0,        32'h00000005, 4'd5},  // R5 unchanged
        {2'd1, 12'h108, 32'h00001000, 32'h0,        4'd2},  // R2 set bit 12
        {2'd2, 12'h108, 32'h0,        32'hFFFFFFFF, 4'd2},  // R2 / R10
        {2'd1, 12'h104, 32'h00000000, 32'h0,        4'd4},  // R4 load zero
        {2'd2, 12'h104, 32'h0,        32'h00000000, 4'd4},  // R4 readback
        {2'd3, 12'h000, 32'h0,        32'h1,        4'd9},  // R9 level unmasked
        {2'd0, 12'h000, 32'h00C44005, 32'h0,        4'd6},  // R6 bits 14,18,22,23
        {2'd2, 12'h100, 32'h0,        32'h00C44005, 4'd6},  // R6 multi-latch
        {2'd2, 12'h200, 32'h0,        32'h00000000, 4'd10}  // R10 unmapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input string tag, input logic [11:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic set_src(input logic [31:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        @(negedge clk);
        check(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [11:0] a;
            logic [31:0] d;
            logic [31:0] e;
            logic [3:0]  r;
            string tag;
            {k, a, d, e, r} = VEC[i];
            tag = $sformatf("R%0d vec%0d", r, i);
            case (k)
                2'd0: set_src(d);
                2'd1: do_write(a, d);
                2'd2: do_read(tag, a, e);
                default: chk_irq(tag, e[0]);
            endcase
        end

        // Directed: clean state
        set_src(32'h0);
        do_write(12'h100, 32'hFFFFFFFF);
        do_read("R7 all cleared", 12'h100, 32'h0);

        // R8: rise and clear of bit 18 in the same cycle
        @(negedge clk);
        src = 32'h00040000; wr = 1'b1; addr = 12'h100; wdata = 32'h00040000;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        do_read("R8 edge beats clear", 12'h100, 32'h00040000);

        // R12: held source does not relatch after clear
        set_src(32'h80040000);
        do_read("R12 bit31 latched", 12'h100, 32'h80040000);
        do_write(12'h100, 32'h80040000);
        @(negedge clk);
        do_read("R12 no relatch while held", 12'h100, 32'h0);
        set_src(32'h0);
        set_src(32'h80000000);
        do_read("R12 relatch after new rise", 12'h100, 32'h80000000);

        // R11: mask all, then acknowledge all
        do_write(12'h108, 32'hFFFFFFFF);
        do_write(12'h100, 32'hFFFFFFFF);
        do_read("R11 status cleared", 12'h100, 32'h0);
        do_read("R11 mask all ones", 12'h104, 32'hFFFFFFFF);
        chk_irq("R11 irq low", 1'b0);

        // R1: reset in mid-run
        do_write(12'h104, 32'h0);
        set_src(32'h00008000);
        @(negedge clk);
        rst_n = 1'b0;
        src = 32'h0;
        @(negedge clk);
        rst_n = 1'b1;
        do_read("R1 mask after rerest", 12'h104, 32'hFFFFFFFF);
        do_read("R1 status after rerest", 12'h100, 32'h0);
        check("R1 irq after rerest", {31'd0, irq}, 32'd0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule